// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the raster timing for a character-based display. A pixel-clock enable drives a dot counter. The dot counter divides pixels into character cells of programmable width, such as 4, 8, 9 or 16 dots. A horizontal counter in character units steps once per cell. A vertical counter in scan-line units steps once per line, and it can optionally repeat each line for doublescan. From these counters the block derives these outputs:
- display-enable, blanking and sync windows for each axis;
- the row inside the current character cell;
- a memory fetch address for every character clock;
- a text-cursor hit signal.

Software can write the timing inputs at any moment. The block copies them into a working set only at a line boundary, so a write in the middle of a line never disturbs the line in progress. Position 0 on each axis is the first active position. Each counter wraps after it reaches its programmed last value. The block also reports the widest horizontal active extent seen since the frame began.

Top module: `crtc_raster`

## Requirements
- R1: A character clock (`char_tick`) fires on the enabled pixel at which the dot counter equals `cfg_dot_last`, so each cell is `cfg_dot_last`+1 dots wide. The horizontal position advances on each character clock and wraps to 0 after position `cfg_h_total`. With `pix_en` low, no counter moves.
- R2: `h_disp` is high while horizontal position < `cfg_h_act_end`. `v_disp` is high while scan line < `cfg_v_act_end`. `disp_en` is high when both are high.
- R3: Each blank or sync flag is high from its "on" position up to, but not including, its "off" position. When "on" > "off" the window wraps through position 0. When "on" equals "off" the flag stays low.
- R4: `fetch_addr` = (character address AND `cfg_addr_mask`) + `cfg_addr_add`, modulo 2^AW. The character address grows by `cfg_h_step` on every character clock that does not end a line.
- R5: At each line end the character address reloads from the line-start address. The line-start address first grows by `cfg_v_step` whenever the scan line advances, and it returns to 0 when the frame wraps.
- R6: With `cfg_dbl_last` = d, each output line is repeated d+1 times. The scan line, cell row and line-start address advance only on the last repeat.
- R7: `cell_row` steps with the scan line and wraps to 0 after `cfg_row_last`. It also returns to 0 when the frame wraps.
- R8: The masked row is `cell_row` AND `cfg_row_mask`. When `cfg_cur_top` < `cfg_cur_bot`, the cursor row window holds for `cfg_cur_top` <= masked row < `cfg_cur_bot`.
- R9: When `cfg_cur_top` >= `cfg_cur_bot` the window is inverted: it holds when the masked row < `cfg_cur_bot` or the masked row >= `cfg_cur_top`. It therefore always holds when the two values are equal.
- R10: The cursor window is evaluated on the masked row, so rows that differ only in bits outside `cfg_row_mask` behave alike.
- R11: `cursor_hit` requires all three of these at once: the row window holds, `fetch_addr` equals `cfg_cur_addr`, and `disp_en` is high.
- R12: All `cfg_*` inputs are captured during reset and at each line end. A change made during a line has no effect before the next line starts.
- R13: `h_act_peak` loads `cfg_h_act_end` at reset and at each frame wrap. At every other line end it becomes the larger of itself and the new `cfg_h_act_end`.
- R14: After synchronous reset, all counters and addresses are 0. `fetch_addr` therefore equals `cfg_addr_add` and `cell_row` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable |
| cfg_h_total | input | HCW | Last horizontal character position |
| cfg_h_act_end | input | HCW | First horizontal position outside the active area |
| cfg_h_blank_on | input | HCW | Horizontal blank start |
| cfg_h_blank_off | input | HCW | Horizontal blank end |
| cfg_h_sync_on | input | HCW | Horizontal sync start |
| cfg_h_sync_off | input | HCW | Horizontal sync end |
| cfg_v_total | input | VCW | Last scan line of a frame |
| cfg_v_act_end | input | VCW | First scan line outside the active area |
| cfg_v_blank_on | input | VCW | Vertical blank start |
| cfg_v_blank_off | input | VCW | Vertical blank end |
| cfg_v_sync_on | input | VCW | Vertical sync start |
| cfg_v_sync_off | input | VCW | Vertical sync end |
| cfg_dot_last | input | DOTW | Dots per cell minus one |
| cfg_row_last | input | RW | Rows per cell minus one |
| cfg_row_mask | input | RW | Row mask applied for the cursor compare |
| cfg_dbl_last | input | DSW | Line repeat count minus one |
| cfg_h_step | input | AW | Address increment per character |
| cfg_v_step | input | AW | Address increment per scan line |
| cfg_addr_mask | input | AW | Fetch address mask |
| cfg_addr_add | input | AW | Fetch address offset |
| cfg_cur_addr | input | AW | Cursor fetch address |
| cfg_cur_top | input | RW | Cursor window first row |
| cfg_cur_bot | input | RW | Cursor window end row |
| h_disp | output | 1 | Horizontal display enable |
| h_blank | output | 1 | Horizontal blanking |
| h_sync | output | 1 | Horizontal retrace |
| v_disp | output | 1 | Vertical display enable |
| v_blank | output | 1 | Vertical blanking |
| v_sync | output | 1 | Vertical retrace |
| disp_en | output | 1 | Combined display enable |
| char_tick | output | 1 | Character clock (fetch strobe) |
| fetch_addr | output | AW | Masked, offset memory fetch address |
| cell_row | output | RW | Row within the character cell |
| cursor_hit | output | 1 | Cursor shown at this character |
| h_act_peak | output | HCW | Widest horizontal active end in this frame |

## Verification
All outputs are decoded combinationally from registered counters and the working configuration. Each output therefore reflects a given pixel enable right after the rising edge that consumed that enable, with no extra pipeline delay. `char_tick` is the only exception: it is live in the same cycle as `pix_en`.

A configuration write shows up only after the edge that ends the current line. So the mid-line tests write during a line, sample once before that edge and once after it.

The bench drives inputs and samples outputs on the falling edge. It counts flag totals over exactly two frames of dots, starting from the reset state. Each expected count is the programmed window length multiplied by the dot, line and repeat factors.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    // Flags of one raster axis.
    typedef struct packed {
        logic disp;
        logic blank;
        logic sync;
    } axis_flags_t;

    // Half-open window [on, off) that wraps through zero when on > off.
    function automatic logic in_window(input logic [15:0] pos, input logic [15:0] on,
                                       input logic [15:0] off);
        if (on <= off) return (pos >= on) && (pos < off);
        else           return (pos >= on) || (pos < off);
    endfunction

    // Cursor row window: normal when top < bot, inverted otherwise.
    function automatic logic cursor_rows(input logic [7:0] row, input logic [7:0] top,
                                         input logic [7:0] bot);
        if (top < bot) return (row >= top) && (row < bot);
        else           return (row < bot) || (row >= top);
    endfunction

endpackage

// File: rtl/crtc_hcount.sv
module crtc_hcount #(
    parameter int HCW  = 10,
    parameter int AW   = 16,
    parameter int DOTW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pix_en,
    input  logic [DOTW-1:0] dot_last,
    input  logic [HCW-1:0]  h_total,
    input  logic [AW-1:0]   h_step,
    input  logic [AW-1:0]   line_addr,
    output logic [HCW-1:0]  h_pos,
    output logic [AW-1:0]   h_addr,
    output logic            char_tick,
    output logic            line_end
);
    logic [DOTW-1:0] dot;

    assign char_tick = pix_en && (dot >= dot_last);
    assign line_end  = char_tick && (h_pos >= h_total);

    always_ff @(posedge clk) begin
        if (rst) begin
            dot    <= '0;
            h_pos  <= '0;
            h_addr <= '0;
        end else if (pix_en) begin
            if (dot >= dot_last) begin
                dot <= '0;
                if (h_pos >= h_total) begin
                    h_pos  <= '0;
                    h_addr <= line_addr;
                end else begin
                    h_pos  <= h_pos + 1'b1;
                    h_addr <= h_addr + h_step;
                end
            end else begin
                dot <= dot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount #(
    parameter int VCW = 11,
    parameter int AW  = 16,
    parameter int RW  = 5,
    parameter int DSW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_end,
    input  logic [VCW-1:0] v_total,
    input  logic [RW-1:0]  row_last,
    input  logic [DSW-1:0] dbl_last,
    input  logic [AW-1:0]  v_step,
    output logic [VCW-1:0] v_pos,
    output logic [RW-1:0]  cell_row,
    output logic [AW-1:0]  line_addr_nxt,
    output logic           frame_end
);
    logic [DSW-1:0] rep;
    logic [AW-1:0]  v_addr;
    logic           advance;
    logic           last_line;

    assign advance   = (rep >= dbl_last);
    assign last_line = (v_pos >= v_total);
    assign frame_end = line_end && advance && last_line;

    always_comb begin
        if (!advance)      line_addr_nxt = v_addr;
        else if (last_line) line_addr_nxt = '0;
        else               line_addr_nxt = v_addr + v_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep      <= '0;
            v_pos    <= '0;
            cell_row <= '0;
            v_addr   <= '0;
        end else if (line_end) begin
            rep    <= advance ? '0 : rep + 1'b1;
            v_addr <= line_addr_nxt;
            if (advance) begin
                if (last_line) begin
                    v_pos    <= '0;
                    cell_row <= '0;
                end else begin
                    v_pos    <= v_pos + 1'b1;
                    cell_row <= (cell_row >= row_last) ? '0 : cell_row + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/crtc_flags.sv
module crtc_flags
    import crtc_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] act_end,
    input  logic [W-1:0] blank_on,
    input  logic [W-1:0] blank_off,
    input  logic [W-1:0] sync_on,
    input  logic [W-1:0] sync_off,
    output axis_flags_t  flags
);
    always_comb begin
        flags.disp  = (pos < act_end);
        flags.blank = in_window(16'(pos), 16'(blank_on), 16'(blank_off));
        flags.sync  = in_window(16'(pos), 16'(sync_on), 16'(sync_off));
    end
endmodule

// File: rtl/crtc_cursor.sv
module crtc_cursor
    import crtc_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 5
) (
    input  logic [RW-1:0] cell_row,
    input  logic [RW-1:0] row_mask,
    input  logic [RW-1:0] top,
    input  logic [RW-1:0] bot,
    input  logic [AW-1:0] fetch_addr,
    input  logic [AW-1:0] cur_addr,
    input  logic          disp_en,
    output logic          hit
);
    logic row_ok;

    assign row_ok = cursor_rows(8'(cell_row & row_mask), 8'(top), 8'(bot));
    assign hit    = row_ok && disp_en && (fetch_addr == cur_addr);
endmodule

// File: rtl/crtc_raster.sv
module crtc_raster
    import crtc_pkg::*;
#(
    parameter int HCW  = 10,
    parameter int VCW  = 11,
    parameter int AW   = 16,
    parameter int RW   = 5,
    parameter int DOTW = 4,
    parameter int DSW  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pix_en,
    input  logic [HCW-1:0]  cfg_h_total,
    input  logic [HCW-1:0]  cfg_h_act_end,
    input  logic [HCW-1:0]  cfg_h_blank_on,
    input  logic [HCW-1:0]  cfg_h_blank_off,
    input  logic [HCW-1:0]  cfg_h_sync_on,
    input  logic [HCW-1:0]  cfg_h_sync_off,
    input  logic [VCW-1:0]  cfg_v_total,
    input  logic [VCW-1:0]  cfg_v_act_end,
    input  logic [VCW-1:0]  cfg_v_blank_on,
    input  logic [VCW-1:0]  cfg_v_blank_off,
    input  logic [VCW-1:0]  cfg_v_sync_on,
    input  logic [VCW-1:0]  cfg_v_sync_off,
    input  logic [DOTW-1:0] cfg_dot_last,
    input  logic [RW-1:0]   cfg_row_last,
    input  logic [RW-1:0]   cfg_row_mask,
    input  logic [DSW-1:0]  cfg_dbl_last,
    input  logic [AW-1:0]   cfg_h_step,
    input  logic [AW-1:0]   cfg_v_step,
    input  logic [AW-1:0]   cfg_addr_mask,
    input  logic [AW-1:0]   cfg_addr_add,
    input  logic [AW-1:0]   cfg_cur_addr,
    input  logic [RW-1:0]   cfg_cur_top,
    input  logic [RW-1:0]   cfg_cur_bot,
    output logic            h_disp,
    output logic            h_blank,
    output logic            h_sync,
    output logic            v_disp,
    output logic            v_blank,
    output logic            v_sync,
    output logic            disp_en,
    output logic            char_tick,
    output logic [AW-1:0]   fetch_addr,
    output logic [RW-1:0]   cell_row,
    output logic            cursor_hit,
    output logic [HCW-1:0]  h_act_peak
);
    typedef struct packed {
        logic [HCW-1:0]  h_total, h_act_end, h_blank_on, h_blank_off, h_sync_on, h_sync_off;
        logic [VCW-1:0]  v_total, v_act_end, v_blank_on, v_blank_off, v_sync_on, v_sync_off;
        logic [DOTW-1:0] dot_last;
        logic [RW-1:0]   row_last, row_mask;
        logic [DSW-1:0]  dbl_last;
        logic [AW-1:0]   h_step, v_step, addr_mask, addr_add, cur_addr;
        logic [RW-1:0]   cur_top, cur_bot;
    } work_cfg_t;

    work_cfg_t      cfg_in, sh;
    logic [HCW-1:0] h_pos;
    logic [VCW-1:0] v_pos;
    logic [AW-1:0]  h_addr, line_addr_nxt;
    logic           line_end, frame_end;
    axis_flags_t    hf, vf;

    assign cfg_in = '{cfg_h_total, cfg_h_act_end, cfg_h_blank_on, cfg_h_blank_off,
                      cfg_h_sync_on, cfg_h_sync_off,
                      cfg_v_total, cfg_v_act_end, cfg_v_blank_on, cfg_v_blank_off,
                      cfg_v_sync_on, cfg_v_sync_off,
                      cfg_dot_last, cfg_row_last, cfg_row_mask, cfg_dbl_last,
                      cfg_h_step, cfg_v_step, cfg_addr_mask, cfg_addr_add, cfg_cur_addr,
                      cfg_cur_top, cfg_cur_bot};

    // Working configuration: captured only in reset and at a line boundary.
    always_ff @(posedge clk) begin
        if (rst || line_end) sh <= cfg_in;
    end

    // Widest active end since the frame began.
    always_ff @(posedge clk) begin
        if (rst)                        h_act_peak <= cfg_h_act_end;
        else if (frame_end)             h_act_peak <= cfg_h_act_end;
        else if (line_end && cfg_h_act_end > h_act_peak) h_act_peak <= cfg_h_act_end;
    end

    crtc_hcount #(.HCW(HCW), .AW(AW), .DOTW(DOTW)) u_h (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .dot_last(sh.dot_last), .h_total(sh.h_total), .h_step(sh.h_step),
        .line_addr(line_addr_nxt),
        .h_pos(h_pos), .h_addr(h_addr), .char_tick(char_tick), .line_end(line_end)
    );

    crtc_vcount #(.VCW(VCW), .AW(AW), .RW(RW), .DSW(DSW)) u_v (
        .clk(clk), .rst(rst), .line_end(line_end),
        .v_total(sh.v_total), .row_last(sh.row_last), .dbl_last(sh.dbl_last),
        .v_step(sh.v_step),
        .v_pos(v_pos), .cell_row(cell_row), .line_addr_nxt(line_addr_nxt),
        .frame_end(frame_end)
    );

    crtc_flags #(.W(HCW)) u_hf (
        .pos(h_pos), .act_end(sh.h_act_end),
        .blank_on(sh.h_blank_on), .blank_off(sh.h_blank_off),
        .sync_on(sh.h_sync_on), .sync_off(sh.h_sync_off), .flags(hf)
    );

    crtc_flags #(.W(VCW)) u_vf (
        .pos(v_pos), .act_end(sh.v_act_end),
        .blank_on(sh.v_blank_on), .blank_off(sh.v_blank_off),
        .sync_on(sh.v_sync_on), .sync_off(sh.v_sync_off), .flags(vf)
    );

    assign h_disp     = hf.disp;
    assign h_blank    = hf.blank;
    assign h_sync     = hf.sync;
    assign v_disp     = vf.disp;
    assign v_blank    = vf.blank;
    assign v_sync     = vf.sync;
    assign disp_en    = hf.disp && vf.disp;
    assign fetch_addr = (h_addr & sh.addr_mask) + sh.addr_add;

    crtc_cursor #(.AW(AW), .RW(RW)) u_cur (
        .cell_row(cell_row), .row_mask(sh.row_mask),
        .top(sh.cur_top), .bot(sh.cur_bot),
        .fetch_addr(fetch_addr), .cur_addr(sh.cur_addr),
        .disp_en(disp_en), .hit(cursor_hit)
    );
endmodule

// File: rtl/crtc_raster_chk.sv
module crtc_raster_chk #(
    parameter int HCW = 10,
    parameter int VCW = 11,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           pix_en,
    input logic           char_tick,
    input logic           line_end,
    input logic [HCW-1:0] h_pos,
    input logic [VCW-1:0] v_pos,
    input logic [AW-1:0]  h_addr,
    input logic [HCW-1:0] sh_h_total,
    input logic [VCW-1:0] sh_v_total,
    input logic [AW-1:0]  sh_h_step,
    input logic [HCW-1:0] sh_h_act_end,
    input logic           disp_en,
    input logic           cursor_hit,
    input logic [HCW-1:0] h_act_peak
);
    AST_HPOS_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (char_tick && h_pos == sh_h_total) |=> (h_pos == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(h_pos) && $stable(v_pos) && $stable(h_addr))); // R1

    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (rst)
        (char_tick && !line_end) |=> (h_addr == $past(h_addr) + $past(sh_h_step))); // R4

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> ($stable(sh_h_total) && $stable(sh_v_total) && $stable(sh_h_step))); // R12

    AST_CURSOR_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        cursor_hit |-> disp_en); // R11

    AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (rst)
        h_act_peak >= sh_h_act_end); // R13
endmodule

bind crtc_raster crtc_raster_chk #(.HCW(HCW), .VCW(VCW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .pix_en(pix_en), .char_tick(char_tick), .line_end(line_end),
    .h_pos(h_pos), .v_pos(v_pos), .h_addr(h_addr),
    .sh_h_total(sh.h_total), .sh_v_total(sh.v_total), .sh_h_step(sh.h_step),
    .sh_h_act_end(sh.h_act_end), .disp_en(disp_en), .cursor_hit(cursor_hit),
    .h_act_peak(h_act_peak)
);

// File: tb/sim_crtc_raster.sv
`timescale 1ns/1ps
module sim_crtc_raster;
    localparam int HCW = 10, VCW = 11, AW = 16, RW = 5, DOTW = 4, DSW = 2;

    // Fields: htot hact hbon hboff hson hsoff vtot vact vbon vboff vson vsoff dotlast dbl
    localparam int NV = 3;
    localparam int NF = 14;
    localparam int TBL [NV][NF] = '{
        '{ 9,  8,  8, 10,  8,  9, 5, 4, 4, 6, 5, 6, 7, 0},
        '{11,  9, 10,  1, 11,  0, 7, 5, 6, 1, 7, 0, 8, 1},
        '{15, 12, 12, 15, 13, 14, 3, 3, 3, 3, 0, 2, 3, 2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pix_en = 1'b0;
    logic [HCW-1:0]  c_htot, c_hact, c_hbon, c_hboff, c_hson, c_hsoff;
    logic [VCW-1:0]  c_vtot, c_vact, c_vbon, c_vboff, c_vson, c_vsoff;
    logic [DOTW-1:0] c_dot;
    logic [RW-1:0]   c_rlast, c_rmask, c_ctop, c_cbot;
    logic [DSW-1:0]  c_dbl;
    logic [AW-1:0]   c_hstep, c_vstep, c_amask, c_aadd, c_caddr;

    logic h_disp, h_blank, h_sync, v_disp, v_blank, v_sync, disp_en, char_tick, cursor_hit;
    logic [AW-1:0]  fetch_addr;
    logic [RW-1:0]  cell_row;
    logic [HCW-1:0] h_act_peak;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crtc_raster #(.HCW(HCW), .VCW(VCW), .AW(AW), .RW(RW), .DOTW(DOTW), .DSW(DSW)) u0 (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .cfg_h_total(c_htot), .cfg_h_act_end(c_hact), .cfg_h_blank_on(c_hbon),
        .cfg_h_blank_off(c_hboff), .cfg_h_sync_on(c_hson), .cfg_h_sync_off(c_hsoff),
        .cfg_v_total(c_vtot), .cfg_v_act_end(c_vact), .cfg_v_blank_on(c_vbon),
        .cfg_v_blank_off(c_vboff), .cfg_v_sync_on(c_vson), .cfg_v_sync_off(c_vsoff),
        .cfg_dot_last(c_dot), .cfg_row_last(c_rlast), .cfg_row_mask(c_rmask),
        .cfg_dbl_last(c_dbl), .cfg_h_step(c_hstep), .cfg_v_step(c_vstep),
        .cfg_addr_mask(c_amask), .cfg_addr_add(c_aadd), .cfg_cur_addr(c_caddr),
        .cfg_cur_top(c_ctop), .cfg_cur_bot(c_cbot),
        .h_disp(h_disp), .h_blank(h_blank), .h_sync(h_sync),
        .v_disp(v_disp), .v_blank(v_blank), .v_sync(v_sync), .disp_en(disp_en),
        .char_tick(char_tick), .fetch_addr(fetch_addr), .cell_row(cell_row),
        .cursor_hit(cursor_hit), .h_act_peak(h_act_peak)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic set_defaults();
        c_htot = 10'd9;  c_hact = 10'd8;  c_hbon = 10'd0; c_hboff = 10'd0; c_hson = 10'd0; c_hsoff = 10'd0;
        c_vtot = 11'd5;  c_vact = 11'd4;  c_vbon = 11'd0; c_vboff = 11'd0; c_vson = 11'd0; c_vsoff = 11'd0;
        c_dot = 4'd0; c_rlast = 5'd15; c_rmask = 5'h1F; c_dbl = 2'd0;
        c_hstep = 16'd1; c_vstep = 16'd0; c_amask = 16'hFFFF; c_aadd = 16'd0; c_caddr = 16'hFFFF;
        c_ctop = 5'd0; c_cbot = 5'd0;
    endtask

    task automatic do_reset();
        pix_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int span_len(input int on, input int off, input int tot);
        if (on <= off) return off - on;
        return tot + 1 - on + off;
    endfunction

    task automatic run_cursor(input int top, input int bot, input int mask, input int caddr,
                              input int vact, output int hits);
        set_defaults();
        c_htot = 10'd0; c_hact = 10'd1; c_vtot = 11'd31; c_vact = VCW'(vact);
        c_hstep = 16'd0; c_vstep = 16'd0; c_aadd = 16'h0300; c_caddr = AW'(caddr);
        c_rmask = RW'(mask); c_ctop = RW'(top); c_cbot = RW'(bot);
        do_reset();
        pix_en = 1'b1;
        hits = 0;
        for (int r = 0; r < 16; r++) begin
            if (cursor_hit) hits++;
            @(negedge clk);
        end
        pix_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin : main
        int hits;
        set_defaults();

        // Table walk: flag totals over two whole frames (R1 R2 R3 R5 R6)
        for (int v = 0; v < NV; v++) begin
            int ht, dl, vt, db, nd;
            int n_hd, n_hb, n_hs, n_vd, n_vb, n_vs, n_de, n_tk;
            set_defaults();
            c_htot = HCW'(TBL[v][0]);  c_hact = HCW'(TBL[v][1]);
            c_hbon = HCW'(TBL[v][2]);  c_hboff = HCW'(TBL[v][3]);
            c_hson = HCW'(TBL[v][4]);  c_hsoff = HCW'(TBL[v][5]);
            c_vtot = VCW'(TBL[v][6]);  c_vact = VCW'(TBL[v][7]);
            c_vbon = VCW'(TBL[v][8]);  c_vboff = VCW'(TBL[v][9]);
            c_vson = VCW'(TBL[v][10]); c_vsoff = VCW'(TBL[v][11]);
            c_dot = DOTW'(TBL[v][12]); c_dbl = DSW'(TBL[v][13]);
            c_vstep = 16'h0010; c_aadd = 16'h0800;
            ht = TBL[v][0]; vt = TBL[v][6]; dl = TBL[v][12] + 1; db = TBL[v][13] + 1;
            nd = 2 * (ht + 1) * dl * (vt + 1) * db;
            n_hd = 0; n_hb = 0; n_hs = 0; n_vd = 0; n_vb = 0; n_vs = 0; n_de = 0; n_tk = 0;
            do_reset();
            pix_en = 1'b1;
            for (int i = 0; i < nd; i++) begin
                if (h_disp)    n_hd++;
                if (h_blank)   n_hb++;
                if (h_sync)    n_hs++;
                if (v_disp)    n_vd++;
                if (v_blank)   n_vb++;
                if (v_sync)    n_vs++;
                if (disp_en)   n_de++;
                if (char_tick) n_tk++;
                @(negedge clk);
            end
            pix_en = 1'b0;
            check("R1 char ticks", n_tk, 2 * (ht + 1) * (vt + 1) * db);
            check("R2 h_disp dots", n_hd, 2 * TBL[v][1] * dl * (vt + 1) * db);
            check("R2 v_disp dots", n_vd, 2 * TBL[v][7] * db * (ht + 1) * dl);
            check("R2 disp_en dots", n_de, 2 * TBL[v][1] * TBL[v][7] * dl * db);
            check("R3 h_blank dots", n_hb, 2 * span_len(TBL[v][2], TBL[v][3], ht) * dl * (vt + 1) * db);
            check("R3 h_sync dots", n_hs, 2 * span_len(TBL[v][4], TBL[v][5], ht) * dl * (vt + 1) * db);
            check("R3 v_blank dots", n_vb, 2 * span_len(TBL[v][8], TBL[v][9], vt) * (ht + 1) * dl * db);
            check("R3 v_sync dots", n_vs, 2 * span_len(TBL[v][10], TBL[v][11], vt) * (ht + 1) * dl * db);
            check("R5 addr back at frame origin", int'(fetch_addr), 16'h0800);
        end

        // R14: reset state
        set_defaults();
        c_aadd = 16'h0200;
        do_reset();
        check("R14 fetch_addr after reset", int'(fetch_addr), 16'h0200);
        check("R14 cell_row after reset", int'(cell_row), 0);
        check("R14 h_disp at origin", int'(h_disp), 1);
        check("R14 peak after reset", int'(h_act_peak), 8);
        check("R1 no tick while pix_en low", int'(char_tick), 0);
        step(5);
        check("R1 counters idle without pix_en", int'(fetch_addr), 16'h0200);

        // R4 / R5 / R7: masked and offset fetch address, line reload
        set_defaults();
        c_hstep = 16'h0070; c_amask = 16'h00FF; c_aadd = 16'h1000; c_vstep = 16'h0040;
        do_reset();
        pix_en = 1'b1;
        step(3);
        check("R4 masked fetch after 3 chars", int'(fetch_addr), 16'h1050);
        step(7);
        check("R5 reload at line start", int'(fetch_addr), 16'h1040);
        check("R7 cell_row after one line", int'(cell_row), 1);
        pix_en = 1'b0;

        // R6: doublescan repeats the line
        c_dbl = 2'd1;
        do_reset();
        pix_en = 1'b1;
        step(10);
        check("R6 repeated line keeps address", int'(fetch_addr), 16'h1000);
        check("R6 repeated line keeps row", int'(cell_row), 0);
        step(10);
        check("R6 address after second repeat", int'(fetch_addr), 16'h1040);
        check("R6 row after second repeat", int'(cell_row), 1);
        pix_en = 1'b0;

        // R7: cell row wrap and frame restart
        set_defaults();
        c_htot = 10'd0; c_hact = 10'd1; c_rlast = 5'd2; c_vtot = 11'd10; c_vact = 11'd11;
        do_reset();
        pix_en = 1'b1;
        step(3);
        check("R7 row wraps after last", int'(cell_row), 0);
        step(2);
        check("R7 row mid cell", int'(cell_row), 2);
        step(6);
        check("R7 row restarts at frame wrap", int'(cell_row), 0);
        pix_en = 1'b0;

        // R8..R11: cursor window
        run_cursor(3, 6, 31, 16'h0300, 32, hits);
        check("R8 normal window rows", hits, 3);
        run_cursor(6, 3, 31, 16'h0300, 32, hits);
        check("R9 inverted window rows", hits, 13);
        run_cursor(4, 4, 31, 16'h0300, 32, hits);
        check("R9 equal bounds always on", hits, 16);
        run_cursor(2, 4, 7, 16'h0300, 32, hits);
        check("R10 masked row compare", hits, 4);
        run_cursor(3, 6, 31, 16'h0301, 32, hits);
        check("R11 address mismatch hides cursor", hits, 0);
        run_cursor(3, 6, 31, 16'h0300, 4, hits);
        check("R11 cursor gated by display", hits, 1);

        // R12 / R13: mid-line write deferred, peak tracking
        set_defaults();
        c_vtot = 11'd1; c_vact = 11'd2;
        do_reset();
        pix_en = 1'b1;
        step(3);
        c_hact = 10'd2;
        check("R12 mid-line write not yet applied", int'(h_disp), 1);
        step(7);
        step(3);
        check("R12 write applied on next line", int'(h_disp), 0);
        check("R13 peak keeps larger end", int'(h_act_peak), 8);
        step(7);
        check("R13 peak reloads at frame wrap", int'(h_act_peak), 2);
        pix_en = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule